// File: doc/BRIEF.md
# Rectangle Scan Order Address Generator

This block produces the pixel coordinates of a rectangular transfer, one coordinate per cycle, for use by a pixel mover that reads or fills a frame store. The rectangle is always described by its lower-left pixel together with a width and a height, whatever direction is used to walk it. A one-cycle start pulse captures that description together with a horizontal-reverse flag and a two-bit vertical mode. The block then emits (x, y) pairs under a valid/ready handshake. It marks the first pixel of every scanline and the final pixel of the rectangle, and pulses done once the transfer is over.

The walk is always row-major: a scanline is finished before the next one begins. The horizontal flag picks left-to-right (0) or right-to-left (1) within each scanline. The vertical mode picks one of four scanline orders:

| Mode | Order |
|---|---|
| 0 | Bottom to top |
| 1 | Top to bottom |
| 2 | Every other line, bottom to top |
| 3 | Every other line, top to bottom |

The interlaced modes suit field-by-field video writes.

The controller has three states:

| State | Role |
|---|---|
| IDLE | Waiting for a start |
| SCAN | Coordinates are offered |
| DONE | Holds the one-cycle done pulse |

It has four transitions:

| Transition | Condition |
|---|---|
| IDLE to SCAN | Start with a non-empty rectangle |
| IDLE to DONE | Start with a zero width or height |
| SCAN to DONE | Handshake of the last pixel |
| DONE to IDLE | Always |

Top module: `rect_scan_gen`

## Requirements
- R1: After reset, out_valid and done are 0 and stay 0 until a start is given.
- R2: With hrev=0 and vmode=0, the coordinates run x = org_x .. org_x+width-1 within each row, for rows y = org_y, org_y+1, .. org_y+height-1 in that order, and the first coordinate is offered in the cycle after start.
- R3: With hrev=1, every row runs from x = org_x+width-1 down to org_x; the row order is unchanged.
- R4: With vmode=1, the rows run from y = org_y+height-1 down to org_y.
- R5: With vmode=2, the rows visited are org_y, org_y+2, org_y+4, .. The transfer ends when the next row would pass org_y+height-1.
- R6: With vmode=3, the rows visited are org_y+height-1, org_y+height-3, .. The transfer ends when the next row would fall below org_y.
- R7: out_line_first is 1 exactly on the first coordinate of each visited row.
- R8: out_last is 1 only on the final coordinate. done is high for exactly one cycle, in the cycle after that coordinate's handshake, and out_valid is 0 while done is high.
- R9: While out_valid=1 and out_ready=0, the offered coordinate and flags hold and out_valid stays 1.
- R10: A start with width=0 or height=0 produces no coordinates, and done is 1 in the cycle after the start.
- R11: A start given while a transfer is running, or during the done cycle, has no effect on the sequence and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, sampled only in IDLE |
| org_x | input | COORD_W | Left column of the rectangle |
| org_y | input | COORD_W | Bottom row of the rectangle |
| width | input | DIM_W | Pixels per row |
| height | input | DIM_W | Rows in the rectangle |
| hrev | input | 1 | 1 = right to left within a row |
| vmode | input | 2 | Vertical order: 0 up, 1 down, 2 alternate up, 3 alternate down |
| out_ready | input | 1 | Consumer accepts the offered coordinate |
| out_valid | output | 1 | A coordinate is offered |
| out_x | output | COORD_W | Column of the offered pixel |
| out_y | output | COORD_W | Row of the offered pixel |
| out_line_first | output | 1 | Offered pixel opens a row |
| out_last | output | 1 | Offered pixel is the final one |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situation to reach from the ports is a start that arrives in the middle of a run, carrying a different origin and size. It must leave the latched description and the coordinate stream untouched. The bench raises start with altered fields two cycles into a backpressured transfer. It then compares every remaining coordinate with the original plan and confirms that nothing is offered after the done pulse. The interlaced modes are run with both odd and even heights, so that the end-of-rectangle decision is taken on each side of the stride.

// File: rtl/rect_scan_pkg.sv
package rect_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

    localparam logic [1:0] VM_UP       = 2'd0;
    localparam logic [1:0] VM_DOWN     = 2'd1;
    localparam logic [1:0] VM_UP_ALT   = 2'd2;
    localparam logic [1:0] VM_DOWN_ALT = 2'd3;

endpackage

// File: rtl/scan_axis.sv
// One axis walker: loads a starting position and walks by a stride of 1 or 2
// in either direction, reporting when no further position fits the extent.
module scan_axis #(
    parameter int POS_W = 12,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [POS_W-1:0] origin,
    input  logic [LEN_W-1:0] extent,
    input  logic             reverse,
    input  logic             skip_one,
    output logic [POS_W-1:0] pos,
    output logic             at_begin,
    output logic             at_end
);

    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] rem_q;
    logic             first_q;
    logic             rev_q;
    logic [LEN_W-1:0] stride;
    logic [LEN_W-1:0] stride_q;
    logic             skip_q;
    logic [POS_W-1:0] start_pos;

    assign stride    = skip_one ? LEN_W'(2) : LEN_W'(1);
    assign stride_q  = skip_q ? LEN_W'(2) : LEN_W'(1);
    assign start_pos = reverse ? (origin + POS_W'(extent) - POS_W'(1)) : origin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
            rev_q   <= 1'b0;
            skip_q  <= 1'b0;
        end else if (load) begin
            pos_q   <= start_pos;
            rem_q   <= extent - LEN_W'(1);
            first_q <= 1'b1;
            rev_q   <= reverse;
            skip_q  <= skip_one;
        end else if (step) begin
            pos_q   <= rev_q ? (pos_q - POS_W'(stride_q)) : (pos_q + POS_W'(stride_q));
            rem_q   <= rem_q - stride_q;
            first_q <= 1'b0;
        end
    end

    assign pos      = pos_q;
    assign at_begin = first_q;
    assign at_end   = (rem_q < stride_q);

    // The walker must never be stepped once its last position is reached.
    assert_no_step_past_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> !at_end);

    // A load always leaves the walker at its opening position.
    assert_load_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> at_begin);

    logic unused_stride;
    assign unused_stride = ^stride;

endmodule

// File: rtl/scan_fsm.sv
// Transfer controller: decides when the walkers load and step and when the
// stream and the done pulse are shown.
module scan_fsm
    import rect_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic zero_dim,
    input  logic fire,
    input  logic line_end,
    input  logic rect_end,
    output logic idle,
    output logic launch,
    output logic x_load,
    output logic x_step,
    output logic y_step,
    output logic out_valid,
    output logic done
);

    scan_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = zero_dim ? ST_DONE : ST_SCAN;
            ST_SCAN: if (fire && rect_end) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        idle      = 1'b0;
        launch    = 1'b0;
        x_load    = 1'b0;
        x_step    = 1'b0;
        y_step    = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle   = 1'b1;
                launch = start && !zero_dim;
                x_load = start && !zero_dim;
            end
            ST_SCAN: begin
                out_valid = 1'b1;
                x_step    = fire && !line_end;
                x_load    = fire && line_end && !rect_end;
                y_step    = fire && line_end && !rect_end;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_empty_rect_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && zero_dim) |=> (done && !out_valid));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(fire && rect_end)) |=> out_valid);

endmodule

// File: rtl/rect_scan_gen.sv
module rect_scan_gen
    import rect_scan_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int DIM_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic               hrev,
    input  logic [1:0]         vmode,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic               out_line_first,
    output logic               out_last,
    output logic               done
);

    logic               idle, launch, x_load, x_step, y_step, fire;
    logic               zero_dim, x_end, y_end, x_first, y_first;
    logic               hrev_q;
    logic [COORD_W-1:0] org_x_q;
    logic [DIM_W-1:0]   width_q;
    logic [COORD_W-1:0] x_org_src;
    logic [DIM_W-1:0]   x_len_src;
    logic               x_rev_src;
    logic               v_down, v_alt;

    assign zero_dim = (width == '0) || (height == '0);
    assign v_down   = (vmode == VM_DOWN) || (vmode == VM_DOWN_ALT);
    assign v_alt    = (vmode == VM_UP_ALT) || (vmode == VM_DOWN_ALT);

    // Row restarts reuse the column description captured at launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            org_x_q <= '0;
            width_q <= '0;
            hrev_q  <= 1'b0;
        end else if (launch) begin
            org_x_q <= org_x;
            width_q <= width;
            hrev_q  <= hrev;
        end
    end

    assign x_org_src = idle ? org_x : org_x_q;
    assign x_len_src = idle ? width : width_q;
    assign x_rev_src = idle ? hrev  : hrev_q;

    scan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .zero_dim  (zero_dim),
        .fire      (fire),
        .line_end  (x_end),
        .rect_end  (x_end && y_end),
        .idle      (idle),
        .launch    (launch),
        .x_load    (x_load),
        .x_step    (x_step),
        .y_step    (y_step),
        .out_valid (out_valid),
        .done      (done)
    );

    scan_axis #(.POS_W(COORD_W), .LEN_W(DIM_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (x_load),
        .step     (x_step),
        .origin   (x_org_src),
        .extent   (x_len_src),
        .reverse  (x_rev_src),
        .skip_one (1'b0),
        .pos      (out_x),
        .at_begin (x_first),
        .at_end   (x_end)
    );

    scan_axis #(.POS_W(COORD_W), .LEN_W(DIM_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .step     (y_step),
        .origin   (org_y),
        .extent   (height),
        .reverse  (v_down),
        .skip_one (v_alt),
        .pos      (out_y),
        .at_begin (y_first),
        .at_end   (y_end)
    );

    assign fire           = out_valid && out_ready;
    assign out_line_first = x_first;
    assign out_last       = x_end && y_end;

    logic unused_row_first;
    assign unused_row_first = y_first;

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                       && $stable(out_line_first) && $stable(out_last)));

    assert_last_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    assert_row_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !x_end) |=> ($stable(out_y) && !out_line_first));

endmodule

// File: tb/sim_rect_scan_gen.sv
module sim_rect_scan_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] org_x = '0, org_y = '0;
    logic [DW-1:0] width = '0, height = '0;
    logic          hrev = 1'b0;
    logic [1:0]    vmode = 2'd0;
    logic          out_ready = 1'b0;
    logic          out_valid, out_line_first, out_last, done;
    logic [CW-1:0] out_x, out_y;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int exp_x [0:255];
    int exp_y [0:255];
    bit exp_f [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_scan_gen #(.COORD_W(CW), .DIM_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
        .width(width), .height(height), .hrev(hrev), .vmode(vmode),
        .out_ready(out_ready), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_line_first(out_line_first), .out_last(out_last), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic run_scan(input int ox, input int oy, input int w, input int h,
                            input bit hr, input logic [1:0] vm, input bit bp,
                            input bit poke, input string tag);
        int n = 0;
        int stride = vm[1] ? 2 : 1;
        int idx = 0;
        bit prev_last = 0;
        bit stalled = 0;
        int sx = 0, sy = 0;
        bit ended = 0;
        for (int p = 0; p < h; p += stride) begin
            for (int c = 0; c < w; c++) begin
                exp_y[n] = vm[0] ? (oy + h - 1 - p) : (oy + p);
                exp_x[n] = hr ? (ox + w - 1 - c) : (ox + c);
                exp_f[n] = (c == 0);
                n++;
            end
        end
        @(negedge clk);
        org_x = CW'(ox); org_y = CW'(oy); width = DW'(w); height = DW'(h);
        hrev = hr; vmode = vm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (poke && cyc == 2) begin
                start = 1'b1; org_x = CW'(ox + 50); org_y = CW'(oy + 50);
                width = DW'(1); height = DW'(1); hrev = ~hr; vmode = ~vm;
            end else begin
                start = 1'b0;
            end
            if (prev_last) begin
                check(done == 1'b1, "R8", "done after last handshake", int'(done), 1);
                check(out_valid == 1'b0, "R8", "valid during done", int'(out_valid), 0);
                ended = 1;
                break;
            end
            if (done) begin
                check(0, "R8", "early done at index", idx, n);
                ended = 1;
                break;
            end
            if (stalled) begin
                check(out_valid && int'(out_x) == sx && int'(out_y) == sy, "R9",
                      "held x under stall", int'(out_x), sx);
            end
            if (!out_valid) begin
                check(0, tag, "valid missing at index", idx, n);
                ended = 1;
                break;
            end
            if (!bp || (cyc % 3 != 1)) begin
                out_ready = 1'b1;
                check(int'(out_x) == exp_x[idx], tag, "x", int'(out_x), exp_x[idx]);
                check(int'(out_y) == exp_y[idx], tag, "y", int'(out_y), exp_y[idx]);
                check(out_line_first == exp_f[idx], "R7", "line_first",
                      int'(out_line_first), int'(exp_f[idx]));
                check(out_last == (idx == n - 1), "R8", "last flag",
                      int'(out_last), int'(idx == n - 1));
                prev_last = (idx == n - 1);
                idx++;
                stalled = 0;
            end else begin
                out_ready = 1'b0;
                stalled = 1;
                sx = int'(out_x);
                sy = int'(out_y);
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        start = 1'b0;
        check(ended, "R8", "transfer ended", int'(ended), 1);
        check(idx == n, tag, "pixel count", idx, n);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width one cycle", int'(done), 0);
        check(out_valid == 1'b0, poke ? "R11" : "R8", "idle after done", int'(out_valid), 0);
    endtask

    task automatic run_empty(input int w, input int h);
        @(negedge clk);
        org_x = 12'd3; org_y = 12'd4; width = DW'(w); height = DW'(h);
        hrev = 1'b0; vmode = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R10", "done after empty start", int'(done), 1);
        check(out_valid == 1'b0, "R10", "no coordinate", int'(out_valid), 0);
        @(negedge clk);
        check(done == 1'b0, "R10", "done dropped", int'(done), 0);
        check(out_valid == 1'b0, "R10", "still no coordinate", int'(out_valid), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    endtask

    task automatic test_done_cycle_start();
        // A start held across the done cycle launches nothing (R11).
        @(negedge clk);
        org_x = 12'd1; org_y = 12'd1; width = DW'(0); height = DW'(2);
        start = 1'b1;
        @(negedge clk);
        width = DW'(3);
        check(done == 1'b1, "R11", "done cycle", int'(done), 1);
        @(negedge clk);
        start = 1'b0;
        check(out_valid == 1'b0, "R11", "start in done cycle ignored", int'(out_valid), 0);
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_scan(10, 20, 4, 3, 1'b0, 2'd0, 1'b0, 1'b0, "R2");
        run_scan(7, 5, 5, 2, 1'b1, 2'd0, 1'b1, 1'b0, "R3");
        run_scan(30, 40, 3, 4, 1'b0, 2'd1, 1'b1, 1'b0, "R4");
        run_scan(2, 8, 2, 5, 1'b0, 2'd2, 1'b0, 1'b0, "R5");
        run_scan(2, 8, 3, 4, 1'b0, 2'd2, 1'b1, 1'b0, "R5");
        run_scan(15, 3, 3, 5, 1'b1, 2'd3, 1'b1, 1'b0, "R6");
        run_scan(15, 3, 2, 6, 1'b0, 2'd3, 1'b0, 1'b0, "R6");
        run_scan(9, 9, 1, 1, 1'b1, 2'd1, 1'b0, 1'b0, "R2");
        run_empty(0, 4);
        run_empty(5, 0);
        run_scan(20, 60, 4, 3, 1'b0, 2'd0, 1'b1, 1'b1, "R11");
        test_done_cycle_start();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule